// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block gathers a workstation I/O controller's housekeeping registers behind a simple single-cycle register bus with byte lanes. There are seven address windows, and each has its own select input:
- four plain 8-bit registers: configuration, diagnostic, modem control and an auxiliary function register;
- an 8-bit power-control register;
- a 16-bit LED register;
- a 32-bit system-control register.

Reads are combinational and have no side effects. Writes take effect at the rising clock edge.

The power-control path watches a synchronous power-fail input. It holds a sticky status bit inside a two-state machine. The states are `PF_CLEAR` and `PF_LATCHED`, and the transitions are:
- *latch*: the input rises while the enable bit in configuration is set.
- *input-clear*: any other change of the input.
- *soft-clear*: a power-control write with the clear bit set.

The interrupt output is the status bit gated by the enable bit.

The system-control path is a second two-state machine with the states `RS_IDLE` and `RS_STATUS`. Its only transition, *arm*, is taken on a reset-request write. From then on the register reads 0x02 until power-on reset.

The block also issues three registered one-clock requests: a terminal-count strobe for a floppy controller, a power-off request and a system reset request. Two resets act on the block. The asynchronous active-low power-on reset clears every register. The synchronous warm reset clears the configuration, auxiliary, power-control and modem registers, and keeps the diagnostic, LED and system-control contents.

Top module: `auxctl_regs`

## Requirements
- R1: `irq_out` is 1 exactly when power-control bit 5 (status) reads 1 and configuration bit 3 (power-fail enable) reads 1.
- R2: When `pwr_fail_in` differs from its value at the previous clock edge, the next edge sets status to 1 if the input is 1 and configuration bit 3 is 1. In every other case it clears status. This input event wins over a power-control write at the same edge.
- R3: A power-control write without bit 1 stores data bit 0 in bit 0 and keeps bit 5 unchanged. All other bits read 0.
- R4: A power-control write with data bit 1 set clears status. Only data bit 0 is kept.
- R5: A power-control write with data bit 0 set makes `pwroff_req` 1 for the one cycle after the write edge.
- R6: An auxiliary-register write with data bit 1 set makes `tc_pulse` 1 for the one cycle after the write edge. The register stores the written byte with bit 1 forced to 0.
- R7: A system-control write at offset 0 with data bit 0 set makes the register read 0x00000002 and pulses `sysrst_req` for one cycle. A write with bit 0 clear has no effect.
- R8: Warm reset clears the configuration, auxiliary, power-control and modem registers. It keeps the diagnostic, LED and system-control values.
- R9: The LED register is 16 bits wide, lives at offset 0 and is written per byte lane (`be[0]` for bits 7:0, `be[1]` for bits 15:8). Any nonzero offset in any window reads 0 and ignores writes.
- R10: Power-on reset clears every register, including diagnostic, LED and system control.
- R11: `tc_pulse`, `pwroff_req` and `sysrst_req` are 0 whenever warm reset or power-on reset is active.
- R12: The configuration, diagnostic and modem registers store all 8 bits when `be[0]` is set and ignore writes with `be[0]` clear. A read changes nothing.
- R13: Status is write-protected. Configuration writes and power-control writes without the clear bit leave it unchanged while the input is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| sel_cfg | input | 1 | Configuration window select |
| sel_diag | input | 1 | Diagnostic window select |
| sel_modem | input | 1 | Modem control window select |
| sel_aux1 | input | 1 | Auxiliary function window select |
| sel_aux2 | input | 1 | Power-control window select |
| sel_led | input | 1 | LED window select |
| sel_sysctl | input | 1 | System-control window select |
| ofs | input | 2 | Byte offset inside the selected window |
| wr_en | input | 1 | Write strobe |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected window |
| pwr_fail_in | input | 1 | Power-fail indication, synchronous |
| irq_out | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Terminal-count strobe |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System reset request pulse |

## Verification
A vector table writes to each window with all-ones bytes, with patterns that drop the clear bit or the strobe bit, with partial byte enables and with no byte enables. Read-back then shows which bits each register stores, masks or ignores. Directed sequences drive the power-fail input through rise, fall and rise-while-disabled, and toggle the enable, soft-clear and non-clear writes in between. This separates the latch, input-clear and soft-clear transitions from mere interrupt gating. Separate warm and power-on reset phases show which registers survive each reset, and whether a pending request pulse is suppressed under warm reset.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
    localparam int BUS_W = 32;
    localparam int OFS_W = 2;
    localparam int REG_W = 8;
    localparam int LED_W = 16;

    // bit positions that software decodes
    localparam int CFG_PFEN = 3;
    localparam int A1_TC    = 1;
    localparam int A2_OFF   = 0;
    localparam int A2_CLR   = 1;
    localparam int A2_STAT  = 5;
    localparam int SC_REQ   = 0;
    localparam int SC_STATUS_CODE = 2;

    typedef enum logic [0:0] {PF_CLEAR, PF_LATCHED} pf_state_t;
    typedef enum logic [0:0] {RS_IDLE, RS_STATUS}   rs_state_t;
endpackage

// File: rtl/auxctl_misc.sv
module auxctl_misc
    import auxctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         warm_rst,
    input  logic         cfg_we,
    input  logic         diag_we,
    input  logic         modem_we,
    input  logic         aux1_we,
    input  logic [W-1:0] wbyte,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] diag_q,
    output logic [W-1:0] modem_q,
    output logic [W-1:0] aux1_q,
    output logic         tc_pulse
);
    localparam int NPLAIN = 3;
    // index 0 cfg, 1 diag, 2 modem; a set bit means warm reset clears it
    localparam logic [NPLAIN-1:0] WARM_CLR = 3'b101;
    localparam logic [W-1:0] TC_MASK = W'(1) << A1_TC;

    logic [NPLAIN-1:0] we_vec;
    logic [W-1:0]      plain_q [NPLAIN];
    logic              tc_q;

    assign we_vec = {modem_we, diag_we, cfg_we};

    for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                plain_q[i] <= '0;
            end else if (warm_rst && WARM_CLR[i]) begin
                plain_q[i] <= '0;
            end else if (we_vec[i]) begin
                plain_q[i] <= wbyte;
            end
        end
    end

    assign cfg_q   = plain_q[0];
    assign diag_q  = plain_q[1];
    assign modem_q = plain_q[2];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            aux1_q <= '0;
            tc_q   <= 1'b0;
        end else if (warm_rst) begin
            aux1_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            tc_q <= aux1_we && wbyte[A1_TC];
            if (aux1_we) begin
                aux1_q <= wbyte & ~TC_MASK;
            end
        end
    end

    assign tc_pulse = tc_q && !warm_rst;
endmodule

// File: rtl/auxctl_pwr.sv
module auxctl_pwr
    import auxctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         warm_rst,
    input  logic         aux2_we,
    input  logic [1:0]   wbits,
    input  logic         pf_in,
    input  logic         pf_en,
    output logic [W-1:0] aux2_q,
    output logic         irq,
    output logic         pwroff_req
);
    pf_state_t st, st_nxt;
    logic      pf_q;
    logic      pf_evt;
    logic      off_q;
    logic      off_pulse_q;

    assign pf_evt = pf_in != pf_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st   <= PF_CLEAR;
            pf_q <= 1'b0;
        end else begin
            st   <= st_nxt;
            pf_q <= pf_in;
        end
    end

    always_comb begin
        st_nxt = st;
        if (warm_rst) begin
            st_nxt = PF_CLEAR;
        end else begin
            unique case (st)
                PF_CLEAR: begin
                    if (pf_evt && pf_in && pf_en) st_nxt = PF_LATCHED;   // latch
                end
                PF_LATCHED: begin
                    if (pf_evt) begin
                        st_nxt = (pf_in && pf_en) ? PF_LATCHED : PF_CLEAR; // input-clear
                    end else if (aux2_we && wbits[A2_CLR]) begin
                        st_nxt = PF_CLEAR;                                // soft-clear
                    end
                end
                default: st_nxt = PF_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            off_q       <= 1'b0;
            off_pulse_q <= 1'b0;
        end else if (warm_rst) begin
            off_q       <= 1'b0;
            off_pulse_q <= 1'b0;
        end else begin
            off_pulse_q <= aux2_we && wbits[A2_OFF];
            if (aux2_we) begin
                off_q <= wbits[A2_OFF];
            end
        end
    end

    always_comb begin
        aux2_q          = '0;
        aux2_q[A2_OFF]  = off_q;
        aux2_q[A2_STAT] = st == PF_LATCHED;
    end

    assign irq        = (st == PF_LATCHED) && pf_en;
    assign pwroff_req = off_pulse_q && !warm_rst;
endmodule

// File: rtl/auxctl_sysunit.sv
module auxctl_sysunit
    import auxctl_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int LW = LED_W
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            warm_rst,
    input  logic            sc_we,
    input  logic            sc_bit,
    input  logic            led_we,
    input  logic [LW/8-1:0] led_be,
    input  logic [LW-1:0]   led_wd,
    output logic [DW-1:0]   sc_q,
    output logic [LW-1:0]   led_q,
    output logic            sysrst_req
);
    localparam int NLANE = LW / 8;
    localparam logic [DW-1:0] STATUS_VAL = DW'(SC_STATUS_CODE);

    rs_state_t st, st_nxt;
    logic      req_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= RS_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RS_IDLE:   if (sc_we && sc_bit && !warm_rst) st_nxt = RS_STATUS; // arm
            RS_STATUS: st_nxt = RS_STATUS;
            default:   st_nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        req_q <= 1'b0;
        else if (warm_rst) req_q <= 1'b0;
        else               req_q <= sc_we && sc_bit;
    end

    assign sc_q       = (st == RS_STATUS) ? STATUS_VAL : '0;
    assign sysrst_req = req_q && !warm_rst;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                led_q[g*8 +: 8] <= '0;
            end else if (led_we && led_be[g]) begin
                led_q[g*8 +: 8] <= led_wd[g*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
    import auxctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             sel_cfg,
    input  logic             sel_diag,
    input  logic             sel_modem,
    input  logic             sel_aux1,
    input  logic             sel_aux2,
    input  logic             sel_led,
    input  logic             sel_sysctl,
    input  logic [OFS_W-1:0] ofs,
    input  logic             wr_en,
    input  logic [3:0]       be,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             pwr_fail_in,
    output logic             irq_out,
    output logic             tc_pulse,
    output logic             pwroff_req,
    output logic             sysrst_req
);
    logic             at_base;
    logic             byte_we;
    logic [REG_W-1:0] cfg_q, diag_q, modem_q, aux1_q, aux2_q;
    logic [LED_W-1:0] led_q;
    logic [BUS_W-1:0] sc_q;
    logic             unused_bits;

    assign at_base     = ofs == '0;
    assign byte_we     = wr_en && at_base && be[0];
    assign unused_bits = ^{be[3:2], wdata[BUS_W-1:LED_W]};

    auxctl_misc #(.W(REG_W)) u_misc (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .cfg_we   (byte_we && sel_cfg),
        .diag_we  (byte_we && sel_diag),
        .modem_we (byte_we && sel_modem),
        .aux1_we  (byte_we && sel_aux1),
        .wbyte    (wdata[REG_W-1:0]),
        .cfg_q    (cfg_q),
        .diag_q   (diag_q),
        .modem_q  (modem_q),
        .aux1_q   (aux1_q),
        .tc_pulse (tc_pulse)
    );

    auxctl_pwr #(.W(REG_W)) u_pwr (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst   (warm_rst),
        .aux2_we    (byte_we && sel_aux2),
        .wbits      (wdata[1:0]),
        .pf_in      (pwr_fail_in),
        .pf_en      (cfg_q[CFG_PFEN]),
        .aux2_q     (aux2_q),
        .irq        (irq_out),
        .pwroff_req (pwroff_req)
    );

    auxctl_sysunit #(.DW(BUS_W), .LW(LED_W)) u_sys (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst   (warm_rst),
        .sc_we      (byte_we && sel_sysctl),
        .sc_bit     (wdata[SC_REQ]),
        .led_we     (wr_en && at_base && sel_led),
        .led_be     (be[LED_W/8-1:0]),
        .led_wd     (wdata[LED_W-1:0]),
        .sc_q       (sc_q),
        .led_q      (led_q),
        .sysrst_req (sysrst_req)
    );

    always_comb begin
        rdata = '0;
        if (at_base) begin
            if (sel_cfg)    rdata = rdata | BUS_W'(cfg_q);
            if (sel_diag)   rdata = rdata | BUS_W'(diag_q);
            if (sel_modem)  rdata = rdata | BUS_W'(modem_q);
            if (sel_aux1)   rdata = rdata | BUS_W'(aux1_q);
            if (sel_aux2)   rdata = rdata | BUS_W'(aux2_q);
            if (sel_led)    rdata = rdata | BUS_W'(led_q);
            if (sel_sysctl) rdata = rdata | sc_q;
        end
    end
endmodule

// File: rtl/auxctl_regs_chk.sv
module auxctl_regs_chk (
    input logic        clk,
    input logic        por_n,
    input logic        warm_rst,
    input logic        sel_cfg,
    input logic        sel_diag,
    input logic        sel_modem,
    input logic        sel_aux1,
    input logic        sel_aux2,
    input logic        sel_led,
    input logic        sel_sysctl,
    input logic [1:0]  ofs,
    input logic        wr_en,
    input logic [3:0]  be,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        pwr_fail_in,
    input logic        irq_out,
    input logic        tc_pulse,
    input logic        pwroff_req,
    input logic        sysrst_req
);
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        tc_pulse |-> $past(wr_en && sel_aux1 && ofs == 2'd0 && be[0] && wdata[1])); // R6
    AST_PWROFF_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        pwroff_req |-> $past(wr_en && sel_aux2 && ofs == 2'd0 && be[0] && wdata[0])); // R5
    AST_SYSRST_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        sysrst_req |-> $past(wr_en && sel_sysctl && ofs == 2'd0 && be[0] && wdata[0])); // R7
    AST_QUIET_IN_WARM: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |-> !(tc_pulse || pwroff_req || sysrst_req)); // R11
    AST_IRQ_DROPS_ON_FALL: assert property (@(posedge clk) disable iff (!por_n || warm_rst)
        (!pwr_fail_in && $past(pwr_fail_in)) |=> !irq_out); // R2
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
        $countones({tc_pulse, pwroff_req, sysrst_req}) <= 1 || $past(wr_en)); // R11
endmodule

bind auxctl_regs auxctl_regs_chk u_chk (.*);

// File: tb/auxctl_regs_test.sv
`timescale 1ns/1ps
module auxctl_regs_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        sel_cfg = 0, sel_diag = 0, sel_modem = 0, sel_aux1 = 0;
    logic        sel_aux2 = 0, sel_led = 0, sel_sysctl = 0;
    logic [1:0]  ofs = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwr_fail_in = 1'b0;
    logic        irq_out, tc_pulse, pwroff_req, sysrst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic seen_tc, seen_off, seen_rst;
    logic [31:0] got;

    localparam int W_CFG = 0, W_DIAG = 1, W_MODEM = 2, W_AUX1 = 3;
    localparam int W_AUX2 = 4, W_LED = 5, W_SYS = 6;

    always #5 clk = ~clk;

    auxctl_regs uut (.*);

    typedef struct packed {
        logic [2:0]  win;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] ex;
    } vec_t;
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'h1, 32'h000000A5, 32'h000000A5},  // R12 cfg full byte
        '{3'd1, 4'h1, 32'h0000003C, 32'h0000003C},  // R12 diag
        '{3'd2, 4'h1, 32'h000000FF, 32'h000000FF},  // R12 modem
        '{3'd3, 4'h1, 32'h000000FF, 32'h000000FD},  // R6 strobe bit not stored
        '{3'd4, 4'h1, 32'h000000FF, 32'h00000001},  // R4 clear drops all but bit 0
        '{3'd4, 4'h1, 32'h000000FC, 32'h00000000},  // R3 only bits 0,1 taken
        '{3'd5, 4'h3, 32'h0000BEEF, 32'h0000BEEF},  // R9 both lanes
        '{3'd5, 4'h1, 32'h00001234, 32'h0000BE34},  // R9 low lane only
        '{3'd6, 4'h1, 32'hFFFFFFFE, 32'h00000000},  // R7 bit 0 clear ignored
        '{3'd0, 4'h0, 32'h00000011, 32'h000000A5}   // R12 no lane enable ignored
    };

    task automatic set_sel(input int w);
        sel_cfg    = (w == W_CFG);
        sel_diag   = (w == W_DIAG);
        sel_modem  = (w == W_MODEM);
        sel_aux1   = (w == W_AUX1);
        sel_aux2   = (w == W_AUX2);
        sel_led    = (w == W_LED);
        sel_sysctl = (w == W_SYS);
    endtask

    task automatic do_wr(input int w, input logic [1:0] o, input logic [3:0] b,
                         input logic [31:0] d);
        @(negedge clk);
        set_sel(w); ofs = o; be = b; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        seen_tc = tc_pulse; seen_off = pwroff_req; seen_rst = sysrst_req;
        wr_en = 1'b0; set_sel(-1);
    endtask

    task automatic do_rd(input int w, input logic [1:0] o, output logic [31:0] v);
        @(negedge clk);
        set_sel(w); ofs = o; #1;
        v = rdata;
        set_sel(-1); ofs = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk); pwr_fail_in = v;
        @(posedge clk); #1;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); por_n = 1'b1;

        // R10 reset state
        do_rd(W_CFG, 0, got);  chk("R10 cfg after por", got, 0);
        do_rd(W_SYS, 0, got);  chk("R10 sysctl after por", got, 0);
        chk("R11 outputs idle after por", {29'd0, tc_pulse, pwroff_req, sysrst_req}, 0);
        chk("R1 irq low after por", {31'd0, irq_out}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_wr(int'(VEC[i].win), 2'd0, VEC[i].be, VEC[i].wd);
            do_rd(int'(VEC[i].win), 2'd0, got);
            chk($sformatf("vector %0d readback", i), got, VEC[i].ex);
        end

        // R6 terminal-count pulse
        do_wr(W_AUX1, 0, 4'h1, 32'h02);
        chk("R6 tc high after write", {31'd0, seen_tc}, 1);
        @(posedge clk); #1;
        chk("R6 tc one cycle", {31'd0, tc_pulse}, 0);
        do_rd(W_AUX1, 0, got); chk("R6 aux1 stores zero", got, 0);

        // R5 power-off pulse
        do_wr(W_AUX2, 0, 4'h1, 32'h01);
        chk("R5 pwroff high", {31'd0, seen_off}, 1);
        @(posedge clk); #1;
        chk("R5 pwroff one cycle", {31'd0, pwroff_req}, 0);
        do_wr(W_AUX2, 0, 4'h1, 32'h00);
        chk("R5 no pwroff for bit0 clear", {31'd0, seen_off}, 0);

        // R7 reset request
        do_wr(W_SYS, 0, 4'h1, 32'h01);
        chk("R7 sysrst high", {31'd0, seen_rst}, 1);
        @(posedge clk); #1;
        chk("R7 sysrst one cycle", {31'd0, sysrst_req}, 0);
        do_rd(W_SYS, 0, got); chk("R7 status value", got, 32'h2);

        // power-fail sequences
        do_wr(W_CFG, 0, 4'h1, 32'h08);
        set_pf(1'b1);
        do_rd(W_AUX2, 0, got); chk("R2 latch sets status", got, 32'h20);
        chk("R1 irq with enable", {31'd0, irq_out}, 1);
        do_wr(W_CFG, 0, 4'h1, 32'h00);
        chk("R1 irq gated by enable", {31'd0, irq_out}, 0);
        do_rd(W_AUX2, 0, got); chk("R13 status survives enable off", got, 32'h20);
        do_wr(W_CFG, 0, 4'h1, 32'h08);
        chk("R1 irq back on", {31'd0, irq_out}, 1);
        do_wr(W_AUX2, 0, 4'h1, 32'h01);
        do_rd(W_AUX2, 0, got); chk("R3 keep status with write", got, 32'h21);
        do_wr(W_AUX2, 0, 4'h1, 32'h22);
        do_rd(W_AUX2, 0, got); chk("R4 soft clear", got, 32'h00);
        chk("R4 irq low after clear", {31'd0, irq_out}, 0);
        set_pf(1'b0);
        set_pf(1'b1);
        do_rd(W_AUX2, 0, got); chk("R2 relatch on new rise", got, 32'h20);
        set_pf(1'b0);
        do_rd(W_AUX2, 0, got); chk("R2 fall clears status", got, 32'h00);
        do_wr(W_CFG, 0, 4'h1, 32'h00);
        set_pf(1'b1);
        do_rd(W_AUX2, 0, got); chk("R2 rise while disabled", got, 32'h00);
        set_pf(1'b0);

        // R9 offsets
        do_wr(W_LED, 2'd2, 4'h3, 32'h0000FFFF);
        do_rd(W_LED, 2'd2, got); chk("R9 led offset 2 reads zero", got, 0);
        do_rd(W_LED, 2'd0, got); chk("R9 led unchanged by offset write", got, 32'hBE34);
        do_wr(W_DIAG, 2'd1, 4'h1, 32'h77);
        do_rd(W_DIAG, 2'd0, got); chk("R9 diag offset write ignored", got, 32'h3C);

        // R8 / R11 warm reset
        do_wr(W_DIAG, 0, 4'h1, 32'h5A);
        do_wr(W_CFG, 0, 4'h1, 32'h0F);
        do_wr(W_MODEM, 0, 4'h1, 32'h33);
        do_wr(W_AUX1, 0, 4'h1, 32'h81);
        do_wr(W_AUX2, 0, 4'h1, 32'h01);
        chk("R5 pwroff before warm", {31'd0, seen_off}, 1);
        warm_rst = 1'b1; #1;
        chk("R11 pwroff suppressed in warm reset", {31'd0, pwroff_req}, 0);
        @(posedge clk); #1;
        @(negedge clk); warm_rst = 1'b0;
        do_rd(W_CFG, 0, got);   chk("R8 cfg cleared", got, 0);
        do_rd(W_MODEM, 0, got); chk("R8 modem cleared", got, 0);
        do_rd(W_AUX1, 0, got);  chk("R8 aux1 cleared", got, 0);
        do_rd(W_AUX2, 0, got);  chk("R8 aux2 cleared", got, 0);
        do_rd(W_DIAG, 0, got);  chk("R8 diag kept", got, 32'h5A);
        do_rd(W_SYS, 0, got);   chk("R8 sysctl kept", got, 32'h2);
        do_rd(W_LED, 0, got);   chk("R8 led kept", got, 32'hBE34);

        // R10 power-on reset
        @(negedge clk); por_n = 1'b0;
        @(posedge clk); #1;
        chk("R11 quiet in por", {29'd0, tc_pulse, pwroff_req, sysrst_req}, 0);
        @(negedge clk); por_n = 1'b1;
        do_rd(W_DIAG, 0, got); chk("R10 diag cleared", got, 0);
        do_rd(W_SYS, 0, got);  chk("R10 sysctl cleared", got, 0);
        do_rd(W_LED, 0, got);  chk("R10 led cleared", got, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule